// File: doc/BRIEF.md
# Strapped Terminal Address Monitor

This block learns the terminal address of a remote unit from six strapping lines on a shared I/O data bus. Lines 4:0 carry the address and line 5 carries a parity bit, chosen so that all six lines together hold an odd number of ones. Once reset is released, the block runs a single read cycle on its own. It raises the command strobe and drops the active-low read line together, so an external buffer can be enabled with no address decoding. It keeps the bus word seen on the last cycle of that strobe window and flags the word if its parity is wrong.

An undriven bus floats high, so a unit that has been unplugged shows up as address 31. The block watches the bus on every cycle. When 31 has been present without a break for a minimum time (800 ns by default, turned into a cycle count from the clock period parameter), the block clears a connected flag. The flag is set again as soon as any other address is sampled.

A host reads one 8-bit status word. Bit 7 is the parity error flag, bit 6 is the connected flag, bit 5 is the captured parity bit, and bits 4:0 are the captured address.

Top module: `strap_addr_monitor`

## Requirements
- R1: After reset is released, `bus_strobe` is high for exactly STROBE_CYCLES consecutive cycles (4 by default). After that it stays low until the next reset.
- R2: `bus_strobe` is always high exactly when `bus_rd_n` is low.
- R3: Status bits 4:0 hold `bus_din[4:0]` and status bit 5 holds `bus_din[5]`, both taken on the last cycle of the strobe window.
- R4: Status bit 7 is 1 exactly when the six captured bits contain an even number of ones, i.e. they fail the odd parity check.
- R5: Status bit 6 falls to 0 on the (DISC_CYCLES+1)-th rising edge after `bus_din[4:0]` first shows 31, provided it shows 31 the whole time. DISC_CYCLES is ceil(DISC_NS*1000/CLK_PERIOD_PS), which is 200 by default. `bus_din[5]` does not affect this test.
- R6: Any sampled address other than 31 restarts the count. If status bit 6 was 0, it returns to 1 on the second rising edge after the bus changes.
- R7: Once the fetch is done, status bits 7 and 5:0 do not change while reset stays released, whatever the bus does.
- R8: `rd_data` equals the status word while `rd_en` is 1, and equals 0 while `rd_en` is 0.
- R9: While reset is asserted, and until the fetch completes, the status word is 8'h40 and both strobes are inactive.
- R10: Asserting `rst_n` takes effect without waiting for a clock edge. Each release of reset starts a new fetch that captures the bus again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_din | input | 6 | I/O data bus: [4:0] address straps, [5] parity strap |
| bus_strobe | output | 1 | Command strobe, active high, asserted during the fetch |
| bus_rd_n | output | 1 | Read line, active low, asserted together with the strobe |
| rd_en | input | 1 | Host read enable |
| rd_data | output | 8 | Status word: [7] parity error, [6] connected, [5] parity, [4:0] address |

## Verification
If the fetch sequencer gets into the wrong state, it shows at once on `bus_strobe` and `bus_rd_n`. The strobe window comes out too long, too short or doubled, or the two lines fall out of step, and this is visible in the same cycle. If the capture goes wrong, or if the fields are written again after the fetch, the status fields differ from the strapped word on the first read after the strobe ends. If the disconnect counter is off by even one cycle, the connected flag changes one edge earlier or later than the computed edge. So the bench samples that flag on both sides of the exact edge, once for a clean run of 31 and once for a run broken by a single different sample.

// File: rtl/strap_mon_pkg.sv
package strap_mon_pkg;

  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned STRAP_W  = ADDR_W + 1;
  localparam int unsigned STATUS_W = 8;

  // Address value that a floating, pulled-up bus presents
  localparam logic [ADDR_W-1:0] FLOAT_ADDR = '1;

  typedef enum logic [1:0] {
    FETCH_WAIT   = 2'd0,
    FETCH_STROBE = 2'd1,
    FETCH_DONE   = 2'd2
  } fetch_state_e;

  typedef struct packed {
    logic              par_err;
    logic              connected;
    logic              par_bit;
    logic [ADDR_W-1:0] addr;
  } status_t;

  localparam status_t STATUS_RESET = '{par_err: 1'b0, connected: 1'b1,
                                       par_bit: 1'b0, addr: '0};

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
  import strap_mon_pkg::*;
#(
  parameter int unsigned STROBE_CYCLES = 4,
  localparam int unsigned CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic bus_strobe,
  output logic bus_rd_n,
  output logic cap_pulse,
  output logic fetch_done
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYCLES - 1);

  fetch_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             strobe_q, strobe_d;
  logic             rd_n_q, rd_n_d;
  logic             last_cyc;

  assign last_cyc = (state_q == FETCH_STROBE) && (cnt_q == LAST_CNT);

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      FETCH_WAIT: begin
        state_d = FETCH_STROBE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      FETCH_STROBE: begin
        cnt_en = 1'b1;
        if (last_cyc) begin
          state_d = FETCH_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FETCH_DONE: begin
        state_d = FETCH_DONE;
      end
      default: begin
        state_d = FETCH_DONE;
      end
    endcase
    strobe_d = (state_d == FETCH_STROBE);
    rd_n_d   = !(state_d == FETCH_STROBE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FETCH_WAIT;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      rd_n_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      rd_n_q   <= rd_n_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign bus_strobe = strobe_q;
  assign bus_rd_n   = rd_n_q;
  assign cap_pulse  = last_cyc;
  assign fetch_done = (state_q == FETCH_DONE);

endmodule

// File: rtl/strap_disc_filter.sv
module strap_disc_filter
  import strap_mon_pkg::*;
#(
  parameter int unsigned DISC_CYCLES = 200,
  localparam int unsigned CNT_W = $clog2(DISC_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] samp_addr,
  output logic              connected
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DISC_CYCLES);

  logic [ADDR_W-1:0] samp_q;
  logic [CNT_W-1:0]  run_q, run_d;
  logic              conn_q, conn_d;
  logic              is_float;
  logic              at_limit;

  assign is_float = (samp_q == FLOAT_ADDR);
  assign at_limit = (run_q == LIMIT);

  // next state: saturating run length of floating samples
  always_comb begin
    if (!is_float) begin
      run_d = '0;
    end else if (at_limit) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
    conn_d = (run_d != LIMIT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      run_q  <= '0;
      conn_q <= 1'b1;
    end else begin
      samp_q <= bus_addr;
      run_q  <= run_d;
      conn_q <= conn_d;
    end
  end

  assign samp_addr = samp_q;
  assign connected = conn_q;

endmodule

// File: rtl/strap_status_reg.sv
module strap_status_reg
  import strap_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_pulse,
  input  logic [STRAP_W-1:0] bus_word,
  input  logic               connected,
  output status_t            status
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              par_q, par_d;
  logic              err_q, err_d;

  // next state: load once per fetch
  always_comb begin
    addr_d = bus_word[ADDR_W-1:0];
    par_d  = bus_word[ADDR_W];
    err_d  = ~(^bus_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= STATUS_RESET.addr;
      par_q  <= STATUS_RESET.par_bit;
      err_q  <= STATUS_RESET.par_err;
    end else if (cap_pulse) begin
      addr_q <= addr_d;
      par_q  <= par_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    status.par_err   = err_q;
    status.connected = connected;
    status.par_bit   = par_q;
    status.addr      = addr_q;
  end

endmodule

// File: rtl/strap_addr_monitor.sv
module strap_addr_monitor
  import strap_mon_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned DISC_NS       = 800,
  parameter int unsigned STROBE_CYCLES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] bus_din,
  output logic       bus_strobe,
  output logic       bus_rd_n,
  input  logic       rd_en,
  output logic [7:0] rd_data
);

  localparam int unsigned DISC_CYCLES =
    (DISC_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  logic              rst_sync_n;
  logic              cap_pulse;
  logic              fetch_done;
  logic              connected;
  logic [ADDR_W-1:0] samp_addr;
  status_t           status_q;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  strap_fetch_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_strobe (bus_strobe),
    .bus_rd_n   (bus_rd_n),
    .cap_pulse  (cap_pulse),
    .fetch_done (fetch_done)
  );

  strap_disc_filter #(.DISC_CYCLES(DISC_CYCLES)) u_disc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_din[ADDR_W-1:0]),
    .samp_addr (samp_addr),
    .connected (connected)
  );

  strap_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_pulse (cap_pulse),
    .bus_word  (bus_din),
    .connected (connected),
    .status    (status_q)
  );

  assign rd_data = rd_en ? status_q : '0;

endmodule

// File: rtl/strap_addr_monitor_chk.sv
module strap_addr_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_strobe,
  input logic       bus_rd_n,
  input logic       fetch_done,
  input logic [4:0] samp_addr,
  input logic [7:0] status,
  input logic       rd_en,
  input logic [7:0] rd_data
);

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe == !bus_rd_n); // R2

  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !bus_strobe); // R1

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> ($stable(status[7]) && $stable(status[5:0]))); // R7

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> (status[7] == ~(^status[5:0]))); // R4

  AST_RECONNECT: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_addr != 5'h1F) |=> status[6]); // R6

  AST_DISC_ON_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[6]) |-> (samp_addr == 5'h1F)); // R5

  always_comb begin
    if (!rd_en) begin
      AST_RD_IDLE_ZERO: assert (rd_data == 8'h00); // R8
    end
  end

endmodule

bind strap_addr_monitor strap_addr_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_strobe (bus_strobe),
  .bus_rd_n   (bus_rd_n),
  .fetch_done (fetch_done),
  .samp_addr  (samp_addr),
  .status     (status_q),
  .rd_en      (rd_en),
  .rd_data    (rd_data)
);

// File: tb/sim_strap_addr_monitor.sv
`timescale 1ns/1ps
module sim_strap_addr_monitor;

  localparam int STROBE_N = 4;
  localparam int DISC_N   = 200;   // 800 ns / 4 ns
  localparam int NVEC     = 8;

  // {strap word, expected status}
  localparam logic [13:0] VEC [NVEC] = '{
    {6'h21, 8'hE1}, {6'h01, 8'h41}, {6'h13, 8'h53}, {6'h33, 8'hF3},
    {6'h1F, 8'h5F}, {6'h3F, 8'hFF}, {6'h20, 8'h60}, {6'h00, 8'hC0}
  };

  logic       clk;
  logic       rst_n;
  logic [5:0] strap;
  logic [5:0] idle_bus;
  logic [5:0] bus_din;
  logic       bus_strobe;
  logic       bus_rd_n;
  logic       rd_en;
  logic [7:0] rd_data;

  int n_checks;
  int n_fail;
  int strobe_seen;
  int pair_bad;
  bit finished;

  // external buffer model: straps driven while the read cycle is active
  assign bus_din = (bus_strobe && !bus_rd_n) ? strap : idle_bus;

  strap_addr_monitor u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_din    (bus_din),
    .bus_strobe (bus_strobe),
    .bus_rd_n   (bus_rd_n),
    .rd_en      (rd_en),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (bus_strobe) strobe_seen++;
    if (bus_strobe != !bus_rd_n) pair_bad++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // reset, then let the fetch run; returns strobe cycles seen
  task automatic reset_and_fetch(output int seen);
    int base;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    base = strobe_seen;
    rst_n = 1'b1;
    repeat (STROBE_N + 12) @(negedge clk);
    seen = strobe_seen - base;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int seen;
    int base;
    int pb;
    n_checks = 0; n_fail = 0; strobe_seen = 0; pair_bad = 0; finished = 0;
    rst_n = 1'b0; rd_en = 1'b1; strap = 6'h13; idle_bus = 6'h05;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 status in reset", rd_data, 8'h40);
    check("R9 strobe in reset", bus_strobe, 0);
    check("R9 rd_n in reset", bus_rd_n, 1);

    // vector table: fetch capture and parity
    for (int i = 0; i < NVEC; i++) begin
      strap = VEC[i][13:8];
      pb = pair_bad;
      reset_and_fetch(seen);
      check("R1 strobe length", seen, STROBE_N);
      check("R2 strobe/rd pairing", pair_bad - pb, 0);
      check("R3/R4 captured status", rd_data, VEC[i][7:0]);
    end

    // R7: fields hold after fetch, no second strobe
    base = strobe_seen;
    strap = 6'h2A; idle_bus = 6'h0C;
    repeat (20) @(negedge clk);
    idle_bus = 6'h33;
    repeat (20) @(negedge clk);
    check("R7 fields fixed", rd_data & 8'hBF, 8'hC0 & 8'hBF);
    check("R1 no second fetch", strobe_seen - base, 0);

    // R8: read gating
    rd_en = 1'b0;
    #1;
    check("R8 rd_en low gives zero", rd_data, 0);
    rd_en = 1'b1;

    // R5: clean run of 31, bit5 low (ignored)
    idle_bus = 6'h05;
    repeat (4) @(negedge clk);
    idle_bus = 6'h1F;
    repeat (DISC_N) @(negedge clk);
    check("R5 still connected at limit", rd_data[6], 1);
    @(negedge clk);
    check("R5 disconnected after limit", rd_data[6], 0);

    // R6: reconnect timing
    idle_bus = 6'h3E;
    @(negedge clk);
    check("R6 not yet reconnected", rd_data[6], 0);
    @(negedge clk);
    check("R6 reconnected", rd_data[6], 1);

    // R6: a single non-31 sample restarts the run (bit5 high this time)
    idle_bus = 6'h3F;
    repeat (150) @(negedge clk);
    idle_bus = 6'h1E;
    @(negedge clk);
    idle_bus = 6'h3F;
    repeat (150) @(negedge clk);
    check("R6 run restarted by glitch", rd_data[6], 1);
    repeat (DISC_N - 150) @(negedge clk);
    check("R5 connected before new limit", rd_data[6], 1);
    @(negedge clk);
    check("R5 disconnected at new limit", rd_data[6], 0);

    // R10: asynchronous reset and refetch
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R10 async reset status", rd_data, 8'h40);
    check("R10 async reset strobe", bus_strobe, 0);
    idle_bus = 6'h05;
    strap = 6'h07;
    reset_and_fetch(seen);
    check("R10 refetch strobe length", seen, STROBE_N);
    check("R10 refetch captured", rd_data, 8'h47);

    finished = 1;
    summary();
    $finish;
  end

endmodule